// File: doc/BRIEF.md
# Set-Associative LRU Tag Store

This block holds the tag side of one cache partition that replaces by true least-recently-used order. Every set keeps its ways as a recency stack: position 0 is the most recent and the last position is the next victim. One request port carries a valid strobe, an operation, an address, the current cycle number and, for allocations, the cycle at which the new line's data will be ready. The block answers one cycle later with hit, way and access latency. It also updates the set's recency stack and its per-way valid, touched and ready-time state at that same edge.

Besides the response, the block keeps a hit count, a miss count and the number of tags in use. A warmed-up flag rises the first time every tag in the array has been occupied, and the cycle at which that happened is latched. A lookup that hits a line whose data is still in flight returns the wait until the line is ready, when that wait is longer than the normal hit latency. Data storage, writebacks and coherence sit outside this block.

Top module: `lru_tag_store`

## Requirements
- R1: The address splits into a block offset in the low log2(BLK_BYTES) bits, a set index in the next log2(SETS) bits, and a tag in all bits above. Offset bits have no effect on a result, and a tag that is stored in one set never hits in another set.
- R2: The operation codes are 0 lookup, 1 probe, 2 allocate and 3 invalidate. A request is answered at the clock edge after it is presented, with rsp_valid high for one cycle. A request hits only when one of its set's ways is valid and holds the request tag.
- R3: A lookup hit moves the matching way to the most-recent position. The ways that were ahead of it each drop back one place, and the ways behind it keep their places. It increments hit_count and reports the matching way.
- R4: A lookup miss reports rsp_hit 0 and the base latency. It leaves the counters and the recency order unchanged.
- R5: A lookup hit reports latency HIT_LAT, unless the line's ready time is later than the current cycle by more than HIT_LAT. In that case the latency is ready time minus current cycle.
- R6: An allocate picks the way in the least-recent position of the set and reports it on rsp_way with rsp_hit 0. It moves that way to the most-recent position, writes the request tag and ready time into it, marks it valid and increments miss_count. The line it replaces no longer hits.
- R7: An allocate whose victim way was never touched since reset or since its last invalidate marks it touched and increments tags_in_use. tags_in_use never exceeds SETS*WAYS.
- R8: When tags_in_use first reaches SETS*WAYS, warmed_up goes high and warm_cycle latches the request's current cycle. Both then hold, even when tags_in_use falls and rises again.
- R9: An invalidate that hits clears that way's valid and touched state, decrements tags_in_use and reports the way with rsp_hit 1. An invalidate that misses changes nothing and reports rsp_hit 0.
- R10: A probe reports hit and way with the base latency. It changes neither the recency order nor any counter.
- R11: After reset, every way is invalid and untouched with ready time 0. Each set's order runs from way 0 (most recent) to way WAYS-1 (least recent). All counters are 0, warmed_up is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 0 lookup, 1 probe, 2 allocate, 3 invalidate |
| req_addr | input | ADDR_W | Request address |
| req_now | input | TIME_W | Current cycle number |
| req_ready_time | input | TIME_W | Ready cycle stored on allocate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request tag found valid in its set |
| rsp_way | output | WAY_W | Hit way, or victim way on allocate |
| rsp_lat | output | TIME_W | Access latency in cycles |
| hit_count | output | CNT_W | Lookup hits since reset |
| miss_count | output | CNT_W | Allocations since reset |
| tags_in_use | output | CAP_W | Ways currently marked touched |
| warmed_up | output | 1 | Every tag has been occupied at least once |
| warm_cycle | output | TIME_W | Cycle at which warmed_up rose |

## Verification
The bench uses 4 sets, 16-byte blocks, 4 ways and a base latency of 2. With these values the set index is two bits at address bits 5:4, so one set's stack can be walked through every position with a handful of allocations. The whole array of 16 tags can be filled to trigger the warm-up flag. A base latency of 2 leaves room to test ready times that are 1, 2, 3 and 10 cycles away, which covers both sides of the stretch threshold and the threshold itself.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;

   typedef enum logic [1:0] {
      OP_LOOKUP = 2'd0,
      OP_PROBE  = 2'd1,
      OP_ALLOC  = 2'd2,
      OP_INVAL  = 2'd3
   } tag_op_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lru_addr_split.sv
module lru_addr_split #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int SET_W  = 2,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 26
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  set_idx,
   output logic [TAG_W-1:0]  tag
);

   assign tag = addr[ADDR_W-1 -: TAG_W];

   generate
      if (SET_W == 0) begin : g_one_set
         assign set_idx = '0;
      end else begin : g_many_sets
         assign set_idx = addr[OFF_W +: SET_W];
      end
   endgenerate

endmodule

// File: rtl/lru_recency_stack.sv
module lru_recency_stack #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int IDX_W = 2,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_set,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] lru_way
);

   logic [WAY_W-1:0] order_q [SETS][WAYS];
   logic [WAY_W-1:0] row_nxt [WAYS];
   int               touch_pos;

   assign lru_way = order_q[rd_set][WAYS-1];

   always_comb begin
      touch_pos = 0;
      for (int p = 0; p < WAYS; p++) begin
         if (order_q[rd_set][p] == touch_way) touch_pos = p;
      end
      for (int p = 0; p < WAYS; p++) begin
         if (p == 0)              row_nxt[p] = touch_way;
         else if (p <= touch_pos) row_nxt[p] = order_q[rd_set][p-1];
         else                     row_nxt[p] = order_q[rd_set][p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int p = 0; p < WAYS; p++)
               order_q[s][p] <= WAY_W'(p);
      end else if (touch_en) begin
         for (int p = 0; p < WAYS; p++)
            order_q[rd_set][p] <= row_nxt[p];
      end
   end

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_perm
         logic [WAYS-1:0] seen;
         always_comb begin
            seen = '0;
            for (int p = 0; p < WAYS; p++) seen[order_q[s][p]] = 1'b1;
         end
         // R3: the stack of every set stays a permutation of the ways
         p_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
            seen == {WAYS{1'b1}});
      end
   endgenerate

   // R3: the touched way sits at the head after the update
   p_mru_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> order_q[$past(rd_set)][0] == $past(touch_way));

endmodule

// File: rtl/lru_way_store.sv
module lru_way_store #(
   parameter int SETS   = 4,
   parameter int WAYS   = 4,
   parameter int IDX_W  = 2,
   parameter int WAY_W  = 2,
   parameter int TAG_W  = 26,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_set,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              hit_any,
   output logic [WAY_W-1:0]  hit_way,
   output logic [TIME_W-1:0] hit_ready,
   output logic [WAYS-1:0]   touched_row,
   input  logic              wr_en,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [TIME_W-1:0] wr_ready,
   input  logic              clr_en,
   input  logic [WAY_W-1:0]  clr_way
);

   logic [TAG_W-1:0]  tag_q     [SETS][WAYS];
   logic [TIME_W-1:0] ready_q   [SETS][WAYS];
   logic [WAYS-1:0]   valid_q   [SETS];
   logic [WAYS-1:0]   touched_q [SETS];
   logic [WAYS-1:0]   hit_vec;

   assign touched_row = touched_q[rd_set];

   always_comb begin
      hit_vec   = '0;
      hit_way   = '0;
      hit_ready = '0;
      for (int w = 0; w < WAYS; w++)
         hit_vec[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            hit_way   = WAY_W'(w);
            hit_ready = ready_q[rd_set][w];
         end
      end
   end

   assign hit_any = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s]   <= '0;
            touched_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]   <= TAG_W'(w);
               ready_q[s][w] <= '0;
            end
         end
      end else begin
         if (wr_en) begin
            tag_q[rd_set][wr_way]     <= rd_tag;
            ready_q[rd_set][wr_way]   <= wr_ready;
            valid_q[rd_set][wr_way]   <= 1'b1;
            touched_q[rd_set][wr_way] <= 1'b1;
         end
         if (clr_en) begin
            valid_q[rd_set][clr_way]   <= 1'b0;
            touched_q[rd_set][clr_way] <= 1'b0;
         end
      end
   end

   // R9: a cleared way no longer counts as valid or touched
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !wr_en) |=> !valid_q[$past(rd_set)][$past(clr_way)]
                            && !touched_q[$past(rd_set)][$past(clr_way)]);

   // R6: a written way hits on its new tag
   p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(rd_set)][$past(wr_way)]
                && tag_q[$past(rd_set)][$past(wr_way)] == $past(rd_tag));

endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
   import lru_tag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SETS      = 4,
   parameter int BLK_BYTES = 16,
   parameter int WAYS      = 4,
   parameter int HIT_LAT   = 2,
   parameter int TIME_W    = 16,
   parameter int CNT_W     = 16,
   localparam int OFF_W    = $clog2(BLK_BYTES),
   localparam int SET_W    = $clog2(SETS),
   localparam int IDX_W    = (SET_W > 0) ? SET_W : 1,
   localparam int TAG_W    = ADDR_W - OFF_W - SET_W,
   localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int CAP      = SETS * WAYS,
   localparam int CAP_W    = $clog2(CAP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TIME_W-1:0] req_now,
   input  logic [TIME_W-1:0] req_ready_time,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [TIME_W-1:0] rsp_lat,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count,
   output logic [CAP_W-1:0]  tags_in_use,
   output logic              warmed_up,
   output logic [TIME_W-1:0] warm_cycle
);

   generate
      if (BLK_BYTES < 4 || !is_pow2(BLK_BYTES)) begin : g_bad_blk
         $error("lru_tag_store: BLK_BYTES must be a power of two of at least 4");
      end
      if (!is_pow2(SETS)) begin : g_bad_sets
         $error("lru_tag_store: SETS must be a nonzero power of two");
      end
      if (WAYS < 1) begin : g_bad_ways
         $error("lru_tag_store: WAYS must be at least 1");
      end
      if (HIT_LAT < 1 || HIT_LAT >= (1 << TIME_W)) begin : g_bad_lat
         $error("lru_tag_store: HIT_LAT must be positive and fit TIME_W");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("lru_tag_store: ADDR_W too small for the set and offset fields");
      end
   endgenerate

   localparam logic [TIME_W-1:0] BASE_LAT = TIME_W'(HIT_LAT);

   logic [IDX_W-1:0]  set_idx;
   logic [TAG_W-1:0]  req_tag;
   logic              hit_any;
   logic [WAY_W-1:0]  hit_way;
   logic [TIME_W-1:0] hit_ready;
   logic [WAYS-1:0]   touched_row;
   logic [WAY_W-1:0]  lru_way;

   tag_op_e           op;
   logic              do_lookup_hit;
   logic              do_alloc;
   logic              do_inval_hit;
   logic              touch_en;
   logic [WAY_W-1:0]  touch_way;
   logic              victim_fresh;
   logic [TIME_W-1:0] wait_left;
   logic [TIME_W-1:0] lat_nxt;
   tag_op_e           rsp_op_q;

   assign op = tag_op_e'(req_op);

   lru_addr_split #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .SET_W  (SET_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) u_split (
      .addr    (req_addr),
      .set_idx (set_idx),
      .tag     (req_tag)
   );

   lru_way_store #(
      .SETS   (SETS),
      .WAYS   (WAYS),
      .IDX_W  (IDX_W),
      .WAY_W  (WAY_W),
      .TAG_W  (TAG_W),
      .TIME_W (TIME_W)
   ) u_ways (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_set      (set_idx),
      .rd_tag      (req_tag),
      .hit_any     (hit_any),
      .hit_way     (hit_way),
      .hit_ready   (hit_ready),
      .touched_row (touched_row),
      .wr_en       (do_alloc),
      .wr_way      (lru_way),
      .wr_ready    (req_ready_time),
      .clr_en      (do_inval_hit),
      .clr_way     (hit_way)
   );

   lru_recency_stack #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .IDX_W (IDX_W),
      .WAY_W (WAY_W)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (set_idx),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .lru_way   (lru_way)
   );

   assign do_lookup_hit = req_valid && (op == OP_LOOKUP) && hit_any;
   assign do_alloc      = req_valid && (op == OP_ALLOC);
   assign do_inval_hit  = req_valid && (op == OP_INVAL) && hit_any;
   assign touch_en      = do_lookup_hit || do_alloc;
   assign touch_way     = do_alloc ? lru_way : hit_way;
   assign victim_fresh  = do_alloc && !touched_row[lru_way];
   assign wait_left     = hit_ready - req_now;

   always_comb begin
      lat_nxt = BASE_LAT;
      if (do_lookup_hit && (hit_ready > req_now) && (wait_left > BASE_LAT))
         lat_nxt = wait_left;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= '0;
         rsp_lat   <= '0;
         rsp_op_q  <= OP_LOOKUP;
      end else begin
         rsp_valid <= req_valid;
         rsp_op_q  <= op;
         if (req_valid) begin
            rsp_hit <= (op != OP_ALLOC) && hit_any;
            rsp_way <= do_alloc ? lru_way : (hit_any ? hit_way : '0);
            rsp_lat <= lat_nxt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_count   <= '0;
         miss_count  <= '0;
         tags_in_use <= '0;
         warmed_up   <= 1'b0;
         warm_cycle  <= '0;
      end else begin
         if (do_lookup_hit) hit_count  <= hit_count + 1'b1;
         if (do_alloc)      miss_count <= miss_count + 1'b1;
         if (victim_fresh) begin
            tags_in_use <= tags_in_use + 1'b1;
            if (!warmed_up && (tags_in_use + 1'b1 == CAP_W'(CAP))) begin
               warmed_up  <= 1'b1;
               warm_cycle <= req_now;
            end
         end else if (do_inval_hit) begin
            tags_in_use <= tags_in_use - 1'b1;
         end
      end
   end

   // R5: latency never falls below the base hit latency
   p_lat_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_lat >= BASE_LAT);

   // R10: a probe leaves every counter as it was
   p_probe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op_q == OP_PROBE) |->
         $stable(hit_count) && $stable(miss_count) && $stable(tags_in_use));

   // R6: every allocate adds exactly one miss
   p_miss_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |=> miss_count == $past(miss_count) + 1'b1);

   // R8: the warm-up flag and its cycle stay once set
   p_warm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      warmed_up |=> warmed_up && $stable(warm_cycle));

   // R7: occupied tags are bounded by the array size
   p_inuse_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tags_in_use <= CAP_W'(CAP));

   // R4: a lookup miss changes no counter
   p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_LOOKUP && !hit_any) |=>
         $stable(hit_count) && $stable(miss_count) && $stable(tags_in_use));

endmodule

// File: tb/lru_tag_store_bench.sv
module lru_tag_store_bench;

   localparam int ADDR_W = 32;
   localparam int TIME_W = 16;
   localparam int CNT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [TIME_W-1:0] req_now = '0;
   logic [TIME_W-1:0] req_ready_time = '0;
   logic              rsp_valid;
   logic              rsp_hit;
   logic [1:0]        rsp_way;
   logic [TIME_W-1:0] rsp_lat;
   logic [CNT_W-1:0]  hit_count;
   logic [CNT_W-1:0]  miss_count;
   logic [4:0]        tags_in_use;
   logic              warmed_up;
   logic [TIME_W-1:0] warm_cycle;

   int total = 0;
   int bad   = 0;
   int exp_hits = 0;
   int exp_miss = 0;
   int exp_use  = 0;

   always #4 clk = ~clk;

   lru_tag_store #(
      .ADDR_W    (ADDR_W),
      .SETS      (4),
      .BLK_BYTES (16),
      .WAYS      (4),
      .HIT_LAT   (2),
      .TIME_W    (TIME_W),
      .CNT_W     (CNT_W)
   ) u_lru_tag_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_op         (req_op),
      .req_addr       (req_addr),
      .req_now        (req_now),
      .req_ready_time (req_ready_time),
      .rsp_valid      (rsp_valid),
      .rsp_hit        (rsp_hit),
      .rsp_way        (rsp_way),
      .rsp_lat        (rsp_lat),
      .hit_count      (hit_count),
      .miss_count     (miss_count),
      .tags_in_use    (tags_in_use),
      .warmed_up      (warmed_up),
      .warm_cycle     (warm_cycle)
   );

   localparam logic [1:0] LK = 2'd0, PR = 2'd1, AL = 2'd2, IV = 2'd3;

   function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
      return ADDR_W'((tag << 6) | (set << 4) | off);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // drive a request, then sample at the following falling edge
   task automatic req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input int now, input int rt);
      @(negedge clk);
      req_valid      = 1'b1;
      req_op         = op;
      req_addr       = a;
      req_now        = TIME_W'(now);
      req_ready_time = TIME_W'(rt);
      @(negedge clk);
      req_valid      = 1'b0;
   endtask

   task automatic chk_counts(input string tag);
      chk({tag, " hit_count"},   int'(hit_count),   exp_hits);
      chk({tag, " miss_count"},  int'(miss_count),  exp_miss);
      chk({tag, " tags_in_use"}, int'(tags_in_use), exp_use);
   endtask

   task automatic alloc(input int tag, input int set, input int now, input int rt,
                        input int exp_way, input bit fresh, input string rq);
      req(AL, mk(tag, set, 0), now, rt);
      exp_miss++;
      if (fresh) exp_use++;
      chk({rq, " alloc rsp_valid"}, int'(rsp_valid), 1);
      chk({rq, " alloc rsp_hit"},   int'(rsp_hit),   0);
      chk({rq, " alloc victim way"}, int'(rsp_way),  exp_way);
      chk_counts(rq);
   endtask

   task automatic t_reset;
      chk("R11 rsp_valid", int'(rsp_valid), 0);
      chk("R11 warmed_up", int'(warmed_up), 0);
      chk_counts("R11");
   endtask

   task automatic t_fill_set0;
      req(LK, mk(5, 0, 0), 1, 0);
      chk("R4 lookup miss hit", int'(rsp_hit), 0);
      chk("R4 lookup miss lat", int'(rsp_lat), 2);
      chk_counts("R4");
      // reset order 0,1,2,3: victims come from the tail
      alloc(5, 0, 2, 0, 3, 1, "R6 R7");
      alloc(6, 0, 3, 0, 2, 1, "R6 R7");
      alloc(7, 0, 4, 0, 1, 1, "R6 R7");
      alloc(8, 0, 5, 0, 0, 1, "R6 R7");
   endtask

   task automatic t_recency;
      // order now 0,1,2,3 (tags 8,7,6,5); offset bits ignored
      req(LK, mk(5, 0, 4'hA), 6, 0);
      exp_hits++;
      chk("R1 R3 hit", int'(rsp_hit), 1);
      chk("R3 hit way", int'(rsp_way), 3);
      chk("R3 hit lat", int'(rsp_lat), 2);
      chk_counts("R3");
      req(LK, mk(5, 1, 0), 7, 0);
      chk("R1 other set miss", int'(rsp_hit), 0);
      // order 3,0,1,2: victim way 2, already touched
      alloc(9, 0, 8, 0, 2, 0, "R3 R7");
      req(LK, mk(6, 0, 0), 9, 0);
      chk("R6 replaced tag gone", int'(rsp_hit), 0);
      // order 2,3,0,1
      alloc(10, 0, 10, 0, 1, 0, "R6");
      // order 1,2,3,0; hit way 2 at position 1 -> 2,1,3,0
      req(LK, mk(9, 0, 0), 11, 0);
      exp_hits++;
      chk("R3 mid hit way", int'(rsp_way), 2);
      alloc(12, 0, 12, 0, 0, 0, "R3 tail kept");
   endtask

   task automatic t_probe;
      // order 0,2,1,3: way 3 (tag 5) is least recent
      req(PR, mk(5, 0, 0), 13, 0);
      chk("R10 probe hit", int'(rsp_hit), 1);
      chk("R10 probe way", int'(rsp_way), 3);
      chk("R10 probe lat", int'(rsp_lat), 2);
      chk_counts("R10");
      req(PR, mk(99, 0, 0), 14, 0);
      chk("R10 probe miss", int'(rsp_hit), 0);
      alloc(13, 0, 15, 0, 3, 0, "R10 order kept");
   endtask

   task automatic t_latency;
      alloc(1, 1, 16, 100, 3, 1, "R5 setup");
      req(LK, mk(1, 1, 0), 90, 0);
      exp_hits++;
      chk("R5 lat far", int'(rsp_lat), 10);
      req(LK, mk(1, 1, 0), 97, 0);
      exp_hits++;
      chk("R5 lat three", int'(rsp_lat), 3);
      req(LK, mk(1, 1, 0), 98, 0);
      exp_hits++;
      chk("R5 lat at threshold", int'(rsp_lat), 2);
      req(LK, mk(1, 1, 0), 99, 0);
      exp_hits++;
      chk("R5 lat one", int'(rsp_lat), 2);
      req(LK, mk(1, 1, 0), 120, 0);
      exp_hits++;
      chk("R5 lat past", int'(rsp_lat), 2);
      chk_counts("R5");
   endtask

   task automatic t_invalidate;
      req(IV, mk(1, 1, 0), 121, 0);
      exp_use--;
      chk("R9 inval hit", int'(rsp_hit), 1);
      chk("R9 inval way", int'(rsp_way), 3);
      chk_counts("R9");
      req(LK, mk(1, 1, 0), 122, 0);
      chk("R9 gone after inval", int'(rsp_hit), 0);
      req(IV, mk(2, 1, 0), 123, 0);
      chk("R9 inval miss", int'(rsp_hit), 0);
      chk_counts("R9 miss");
   endtask

   task automatic t_warm;
      // set 1 order 3,0,1,2 with way 3 cleared
      alloc(20, 1, 200, 0, 2, 1, "R7");
      alloc(21, 1, 201, 0, 1, 1, "R7");
      alloc(22, 1, 202, 0, 0, 1, "R7");
      alloc(23, 1, 203, 0, 3, 1, "R7 reused cleared way");
      for (int k = 0; k < 4; k++) alloc(30 + k, 2, 300 + k, 0, 3 - k, 1, "R7");
      for (int k = 0; k < 3; k++) alloc(40 + k, 3, 400 + k, 0, 3 - k, 1, "R7");
      chk("R8 not yet warm", int'(warmed_up), 0);
      alloc(43, 3, 777, 0, 0, 1, "R8");
      chk("R8 warmed", int'(warmed_up), 1);
      chk("R8 warm cycle", int'(warm_cycle), 777);
      alloc(44, 3, 900, 0, 3, 0, "R8 after");
      req(IV, mk(44, 3, 0), 901, 0);
      exp_use--;
      alloc(45, 3, 902, 0, 2, 0, "R8 refill touched");
      req(LK, mk(43, 3, 0), 903, 0);
      exp_hits++;
      chk("R8 still warm", int'(warmed_up), 1);
      chk("R8 cycle held", int'(warm_cycle), 777);
      chk_counts("R8 final");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_fill_set0();
      t_recency();
      t_probe();
      t_latency();
      t_invalidate();
      t_warm();
      repeat (2) @(negedge clk);
      chk("R2 rsp_valid drops", int'(rsp_valid), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule